// File: doc/BRIEF.md
# Interrupt Controller Global Register Block

This block is the 32-bit memory-mapped global area of an interrupt controller. It decodes word-aligned offsets within a 256-byte window. It holds a read-only feature word, a configuration register, a read-only vendor word, a spurious vector and a timer-frequency word. It turns a write to the processor-reset offset into per-processor reset pulses. It forwards writes at the four inter-processor interrupt offsets, as a one-hot strobe with the data, to the vector/priority registers of those interrupt sources, which live elsewhere.

Setting the top bit in a configuration write starts a soft reset of the whole controller. A two-state control machine has the states `ST_RUN` and `ST_SOFTRST`. The transition `RUN->SOFTRST` is taken on a configuration write with bit 31 set. The transition `SOFTRST->RUN` is taken unconditionally after one clock. While the machine is in `ST_SOFTRST`, `ctl_reset` is high for the rest of the controller and every write is dropped. The same write that starts the reset also returns the local registers to their reset values and stores its own data, with bit 31 cleared, as the new configuration.

Top module: `irqc_global_regs`

## Requirements
- R1: An access whose address bits 3:0 are non-zero changes no state and raises no strobe or pulse. A read of such an address returns 0xFFFF_FFFF.
- R2: Offset 0x00 is read-only. It returns (external sources − 1) in bits 26:16, (processors − 1) in bits 12:8 and version 0x03 in bits 7:0, with all other bits zero. With the defaults of 16 sources and 2 processors the value is 0x000F_0103.
- R3: A write to offset 0x20 with bit 31 clear stores bits 30:0 of the data. Reads of 0x20 always return bit 31 as zero.
- R4: A write to 0x20 with bit 31 set moves the machine to `ST_SOFTRST`. `ctl_reset` is then high for exactly the one following clock. The spurious vector and timer-frequency registers return to their reset values, and the configuration register holds the written data with bit 31 cleared.
- R5: While `ctl_reset` is high, writes to any offset have no effect: no register changes, and no `ipi_wr` or `cpu_reset` pulse is produced.
- R6: Offset 0xE0 stores only data bits 7:0 and reads them back zero-extended. Its reset value is 0xFF.
- R7: Offset 0xF0 stores all 32 bits. Its reset value is 0x003F_7A00.
- R8: Offset 0x90 reads as zero. A write there drives data bit i onto `cpu_reset[i]` for exactly the following clock.
- R9: Writes to offsets 0xA0, 0xB0, 0xC0 and 0xD0 raise `ipi_wr[(offset−0xA0)>>4]` in the same cycle, with `ipi_wdata` equal to the write data. These offsets read as zero.
- R10: Offset 0x80 is read-only and returns the vendor parameter, which is zero by default.
- R11: Aligned offsets other than those listed read as zero, and writes to them have no effect.
- R12: After hardware reset the configuration register is 0, and `ctl_reset`, `cpu_reset` and `ipi_wr` are low. `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| addr | input | ADDR_W (8) | Byte offset within the global window |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, combinational from `addr` |
| ipi_wr | output | N_IPI (4) | One-hot forward strobe to an IPI source's vector/priority register |
| ipi_wdata | output | 32 | Data forwarded with `ipi_wr` |
| ctl_reset | output | 1 | One-clock soft-reset pulse to the rest of the controller |
| cpu_reset | output | N_CPU (2) | One-clock reset pulse per processor |

## Verification
The bench sweeps every one of the 256 offsets in three register states and compares each read with a value it computes from the offset map. This sweep exposes a decoder that lets a misaligned access alias onto a real register, because such a read returns register data instead of all ones. The bench issues writes during the single soft-reset cycle. A design that gave those writes priority would keep the written spurious value or emit an IPI strobe. It also checks that the soft-reset pulse lasts one clock and that the configuration read never shows bit 31. A stretched pulse or a stored top bit would show as a wrong value one cycle later. Each IPI slot is written in turn to catch an index computed off by one slot.

// File: rtl/irqc_gr_pkg.sv
package irqc_gr_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_BAD,
        SEL_FEAT,
        SEL_CFG,
        SEL_VEND,
        SEL_PRST,
        SEL_IPI,
        SEL_SPUR,
        SEL_TFREQ
    } gr_sel_e;

    typedef enum logic [0:0] {
        ST_RUN,
        ST_SOFTRST
    } gr_state_e;

    // Row = address bits 7:4 of an aligned offset
    localparam logic [3:0] ROW_FEAT  = 4'h0;
    localparam logic [3:0] ROW_CFG   = 4'h2;
    localparam logic [3:0] ROW_VEND  = 4'h8;
    localparam logic [3:0] ROW_PRST  = 4'h9;
    localparam logic [3:0] ROW_IPI0  = 4'hA;
    localparam logic [3:0] ROW_SPUR  = 4'hE;
    localparam logic [3:0] ROW_TFREQ = 4'hF;

    localparam logic [7:0]  SPUR_RST  = 8'hFF;
    localparam logic [31:0] TFREQ_RST = 32'h003F_7A00;
    localparam int          SOFT_BIT  = 31;

endpackage

// File: rtl/irqc_gr_decode.sv
module irqc_gr_decode
    import irqc_gr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_IPI  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output gr_sel_e           sel,
    output logic [N_IPI-1:0]  ipi_onehot
);
    logic [3:0] row;
    logic       aligned;

    assign row     = addr[7:4];
    assign aligned = (addr[3:0] == 4'h0);

    always_comb begin
        sel = SEL_NONE;
        if (!aligned) begin
            sel = SEL_BAD;
        end else begin
            unique case (row)
                ROW_FEAT:  sel = SEL_FEAT;
                ROW_CFG:   sel = SEL_CFG;
                ROW_VEND:  sel = SEL_VEND;
                ROW_PRST:  sel = SEL_PRST;
                ROW_SPUR:  sel = SEL_SPUR;
                ROW_TFREQ: sel = SEL_TFREQ;
                default:   sel = (ipi_onehot != '0) ? SEL_IPI : SEL_NONE;
            endcase
        end
    end

    for (genvar k = 0; k < N_IPI; k++) begin : g_ipi
        assign ipi_onehot[k] = aligned && (row == ROW_IPI0 + 4'(k));
    end

endmodule

// File: rtl/irqc_gr_ctrl_fsm.sv
module irqc_gr_ctrl_fsm
    import irqc_gr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_req,
    output logic accept,
    output logic ctl_reset
);
    gr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (soft_req) state_d = ST_SOFTRST;
            ST_SOFTRST: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        accept    = (state_q == ST_RUN);
        ctl_reset = (state_q == ST_SOFTRST);
    end

endmodule

// File: rtl/irqc_gr_regs.sv
module irqc_gr_regs
    import irqc_gr_pkg::*;
#(
    parameter int N_CPU = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  gr_sel_e           sel,
    input  logic [31:0]       wdata,
    output logic [31:0]       cfg_q,
    output logic [7:0]        spur_q,
    output logic [31:0]       tfreq_q,
    output logic [N_CPU-1:0]  cpu_rst_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            spur_q    <= SPUR_RST;
            tfreq_q   <= TFREQ_RST;
            cpu_rst_q <= '0;
        end else begin
            cpu_rst_q <= (wr_ok && sel == SEL_PRST) ? wdata[N_CPU-1:0] : '0;
            if (wr_ok) begin
                unique case (sel)
                    SEL_CFG: begin
                        cfg_q <= {1'b0, wdata[30:0]};
                        if (wdata[SOFT_BIT]) begin
                            spur_q  <= SPUR_RST;
                            tfreq_q <= TFREQ_RST;
                        end
                    end
                    SEL_SPUR:  spur_q  <= wdata[7:0];
                    SEL_TFREQ: tfreq_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/irqc_global_regs.sv
module irqc_global_regs
    import irqc_gr_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          N_EXT_SRC = 16,
    parameter int          N_CPU     = 2,
    parameter int          N_IPI     = 4,
    parameter logic [7:0]  VERSION   = 8'h03,
    parameter logic [31:0] VENDOR    = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    output logic [N_IPI-1:0]  ipi_wr,
    output logic [31:0]       ipi_wdata,
    output logic              ctl_reset,
    output logic [N_CPU-1:0]  cpu_reset
);
    localparam logic [31:0] FEATURE = {5'b0, 11'(N_EXT_SRC - 1), 3'b0,
                                       5'(N_CPU - 1), VERSION};

    gr_sel_e            sel;
    logic [N_IPI-1:0]   ipi_hit;
    logic               accept;
    logic               wr_ok;
    logic               soft_req;
    logic [31:0]        cfg_q;
    logic [7:0]         spur_q;
    logic [31:0]        tfreq_q;

    irqc_gr_decode #(.ADDR_W(ADDR_W), .N_IPI(N_IPI)) u_dec (
        .addr       (addr),
        .sel        (sel),
        .ipi_onehot (ipi_hit)
    );

    assign wr_ok    = wr_en && accept;
    assign soft_req = wr_ok && (sel == SEL_CFG) && wdata[SOFT_BIT];

    irqc_gr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_req  (soft_req),
        .accept    (accept),
        .ctl_reset (ctl_reset)
    );

    irqc_gr_regs #(.N_CPU(N_CPU)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .sel       (sel),
        .wdata     (wdata),
        .cfg_q     (cfg_q),
        .spur_q    (spur_q),
        .tfreq_q   (tfreq_q),
        .cpu_rst_q (cpu_reset)
    );

    assign ipi_wr    = wr_ok ? ipi_hit : '0;
    assign ipi_wdata = wdata;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_BAD:   rdata = '1;
                SEL_FEAT:  rdata = FEATURE;
                SEL_CFG:   rdata = cfg_q;
                SEL_VEND:  rdata = VENDOR;
                SEL_SPUR:  rdata = {24'b0, spur_q};
                SEL_TFREQ: rdata = tfreq_q;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqc_global_regs_checker.sv
module irqc_global_regs_checker #(
    parameter int ADDR_W = 8,
    parameter int N_CPU  = 2,
    parameter int N_IPI  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [31:0]       wdata,
    input logic              rd_en,
    input logic [31:0]       rdata,
    input logic [N_IPI-1:0]  ipi_wr,
    input logic              ctl_reset,
    input logic [N_CPU-1:0]  cpu_reset
);
    AST_MISALIGNED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[3:0] != 4'h0) |-> rdata == 32'hFFFF_FFFF); // R1
    AST_MISALIGNED_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[3:0] != 4'h0) |-> ipi_wr == '0); // R1
    AST_CFG_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[7:0] == 8'h20) |-> !rdata[31]); // R3
    AST_SOFTRST_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> !ctl_reset); // R4
    AST_SOFTRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |-> $past(wr_en && addr[7:0] == 8'h20 && wdata[31])); // R4
    AST_NO_FWD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |-> ipi_wr == '0); // R5
    AST_CPU_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_reset != '0) |-> $past(wr_en && addr[7:0] == 8'h90 && !ctl_reset)); // R8
    AST_IPI_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ipi_wr)); // R9
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0); // R12
endmodule

bind irqc_global_regs irqc_global_regs_checker #(
    .ADDR_W(ADDR_W), .N_CPU(N_CPU), .N_IPI(N_IPI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .ipi_wr    (ipi_wr),
    .ctl_reset (ctl_reset),
    .cpu_reset (cpu_reset)
);

// File: tb/irqc_global_regs_test.sv
module irqc_global_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  ipi_wr;
    logic [31:0] ipi_wdata;
    logic        ctl_reset;
    logic [1:0]  cpu_reset;

    int tests = 0;
    int fails = 0;
    logic [31:0] m_cfg;
    logic [7:0]  m_spur;
    logic [31:0] m_tf;
    logic [3:0]  seen_ipi;
    logic [31:0] seen_ipid;

    always #10 clk = ~clk;

    irqc_global_regs uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .ipi_wr(ipi_wr), .ipi_wdata(ipi_wdata),
        .ctl_reset(ctl_reset), .cpu_reset(cpu_reset)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(int a);
        if ((a & 15) != 0) return 32'hFFFF_FFFF;      // R1
        case (a >> 4)
            0:  return (32'(15) << 16) | (32'(1) << 8) | 32'h03; // R2
            2:  return m_cfg;                           // R3
            8:  return 32'h0;                           // R10
            9:  return 32'h0;                           // R8
            10, 11, 12, 13: return 32'h0;               // R9
            14: return {24'h0, m_spur};                 // R6
            15: return m_tf;                            // R7
            default: return 32'h0;                      // R11
        endcase
    endfunction

    task automatic do_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        #2;
        seen_ipi = ipi_wr; seen_ipid = ipi_wdata;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < 256; a++) begin
            logic [31:0] v;
            do_read(8'(a), v);
            check(tag, v, exp_rd(a));
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        m_cfg = 32'h0; m_spur = 8'hFF; m_tf = 32'h003F_7A00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 ctl_reset", 32'(ctl_reset), 0);
        check("R12 cpu_reset", 32'(cpu_reset), 0);
        check("R12 ipi_wr", 32'(ipi_wr), 0);
        addr = 8'h00; #1;
        check("R12 rdata idle", rdata, 0);
        sweep("R1/R2/R6/R7/R11 reset sweep");

        // R6 R7 R3 writes; read-only and unmapped writes R2 R10 R11
        do_write(8'hE0, 32'hABCD_1234); m_spur = 8'h34;
        do_write(8'hF0, 32'h1234_5678); m_tf = 32'h1234_5678;
        do_write(8'h20, 32'h7000_00A5); m_cfg = 32'h7000_00A5;
        check("R3 no soft reset", 32'(ctl_reset), 0);
        do_write(8'h00, 32'hFFFF_FFFF);
        do_write(8'h80, 32'hFFFF_FFFF);
        do_write(8'h40, 32'hFFFF_FFFF);
        check("R11 unmapped no fwd", 32'(seen_ipi), 0);
        sweep("R2/R3/R6/R7/R10/R11 written sweep");

        // R9 IPI forwarding
        for (int k = 0; k < 4; k++) begin
            do_write(8'hA0 + 8'(16 * k), 32'hC0DE_0000 + 32'(k));
            check("R9 ipi strobe", 32'(seen_ipi), 32'(1) << k);
            check("R9 ipi data", seen_ipid, 32'hC0DE_0000 + 32'(k));
        end

        // R1 misaligned writes ignored
        do_write(8'hA4, 32'h1);
        check("R1 misaligned ipi", 32'(seen_ipi), 0);
        do_write(8'hE1, 32'h0000_0000);
        do_write(8'hF8, 32'h0000_0000);
        do_write(8'h2C, 32'h8000_0000);
        check("R1 misaligned cfg no reset", 32'(ctl_reset), 0);
        do_write(8'h91, 32'h3);
        check("R1 misaligned prst", 32'(cpu_reset), 0);
        do_read(8'hE0, v); check("R1 spur kept", v, 32'h34);
        do_read(8'hF0, v); check("R1 tfreq kept", v, 32'h1234_5678);

        // R8 processor reset pulses
        do_write(8'h90, 32'h3);
        check("R8 cpu_reset pulse", 32'(cpu_reset), 3);
        @(negedge clk);
        check("R8 cpu_reset one clk", 32'(cpu_reset), 0);
        do_write(8'h90, 32'h2);
        check("R8 cpu_reset bit1", 32'(cpu_reset), 2);

        // R4 R5 soft reset, write to spur during reset cycle
        do_write(8'h20, 32'h8000_0011); m_cfg = 32'h11;
        m_spur = 8'hFF; m_tf = 32'h003F_7A00;
        check("R4 ctl_reset high", 32'(ctl_reset), 1);
        addr = 8'hE0; wdata = 32'h12; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check("R4 ctl_reset one clk", 32'(ctl_reset), 0);
        do_read(8'hE0, v); check("R5 spur write dropped", v, 32'hFF);
        do_read(8'h20, v); check("R4 cfg keeps data", v, 32'h11);
        do_read(8'hF0, v); check("R4 tfreq reinit", v, 32'h003F_7A00);

        // R5 IPI and processor reset dropped during reset cycle
        do_write(8'h20, 32'h8000_0000); m_cfg = 32'h0;
        addr = 8'hB0; wdata = 32'h5; wr_en = 1'b1;
        #2;
        check("R5 ipi dropped", 32'(ipi_wr), 0);
        @(negedge clk); wr_en = 1'b0;
        do_write(8'h20, 32'h8000_0000);
        addr = 8'h90; wdata = 32'h3; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check("R5 cpu_reset dropped", 32'(cpu_reset), 0);
        sweep("R4 post-reset sweep");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule